// File: doc/BRIEF.md
# Dual-Clock FIFO with Gray-Coded Pointer Crossing

This block buffers data words between two unrelated clock domains in first-in first-out order. The producer pushes words on the write clock and the consumer pops them on the read clock. Each side advances its own binary pointer. The pointer is one bit wider than the storage address, so a full buffer and an empty buffer can be told apart.

Before a pointer leaves its own domain, it is turned into Gray code and held in a register there. In the receiving domain it passes through a chain of flip-flops and is then decoded back to binary. Each flag comes from a plain binary comparison between the local pointer and the pointer received from the other side. Because successive Gray values differ in a single bit, a capture taken while the pointer is changing yields either the old value or the new one. The flags are therefore late but never wrong in the unsafe direction.

The head word is visible on the read data port whenever the empty flag is low. A read enable takes that word and moves the read pointer forward.

Top module: `afifo_gray`

## Requirements
- R1: Words leave on rdata_o in the order they were accepted. The oldest unread word is driven on rdata_o whenever empty_o is 0.
- R2: Each pointer crosses as a registered Gray value. Gray bit i is binary bit i XOR binary bit i+1, and the top bit passes through unchanged. Two successive register values differ in at most one bit.
- R3: empty_o is 1 when the read pointer equals the synchronized write pointer. It is never 0 while no word is held. After a write it falls within 3 read-clock edges.
- R4: full_o is 1 when the local write pointer and the synchronized read pointer differ in the top bit and agree in all address bits. It is never 0 while 2**ADDR_W words are held. After a read it falls within 3 write-clock edges.
- R5: A write while full_o is 1 and a read while empty_o is 1 are ignored, and both pointers stay unchanged.
- R6: wrst_ni clears the write pointer and its synchronizer, and rrst_ni clears the read pointer and its synchronizer. After reset, empty_o is 1 and full_o is 0.
- R7: Starting from empty, exactly 2**ADDR_W writes (16 by default) are accepted before full_o rises, and full_o rises right after the edge that takes the last of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write clock |
| wrst_ni | input | 1 | Write-domain asynchronous reset, active low |
| wen_i | input | 1 | Write request |
| wdata_i | input | DATA_W | Write data |
| full_o | output | 1 | No room left (write domain) |
| rclk_i | input | 1 | Read clock |
| rrst_ni | input | 1 | Read-domain asynchronous reset, active low |
| ren_i | input | 1 | Read request, pops the head word |
| rdata_o | output | DATA_W | Head word |
| empty_o | output | 1 | No word available (read domain) |

## Verification
A write moves the local pointer and the full_o flag at the same write edge, so the bench checks full_o exactly at the next write-clock falling edge while reads are idle. A change of the remote pointer reaches a flag only after the two synchronizer flops, which is at most 3 destination edges. The bench therefore waits 4 destination cycles before it checks that a flag has fallen. During concurrent traffic on clocks with unrelated periods, the bench checks each flag only in the safe direction against a queue model. It updates that model at the falling edge ahead of each accepted transfer, which keeps the comparison conservative.

// File: rtl/gray_enc.sv
module gray_enc #(
  parameter int W = 5
) (
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] gray_o
);
  assign gray_o[W-1] = bin_i[W-1];
  for (genvar i = 0; i < W - 1; i++) begin : g_bit
    assign gray_o[i] = bin_i[i] ^ bin_i[i+1];
  end
endmodule

// File: rtl/gray_dec.sv
module gray_dec #(
  parameter int W = 5
) (
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  // ripple from MSB down
  always_comb begin
    bin_o[W-1] = gray_i[W-1];
    for (int i = W - 2; i >= 0; i--) begin
      bin_o[i] = bin_o[i+1] ^ gray_i[i];
    end
  end
endmodule

// File: rtl/ptr_sync.sv
module ptr_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/afifo_gray.sv
module afifo_gray #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk_i,
  input  logic              wrst_ni,
  input  logic              wen_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              full_o,
  input  logic              rclk_i,
  input  logic              rrst_ni,
  input  logic              ren_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_o
);
  localparam int PTR_W = ADDR_W + 1;

  // write domain
  logic [PTR_W-1:0] wbin_q, wbin_d, wgray_d, wgray_q, rgray_s, rbin_s;
  logic             wr_ok;
  // read domain
  logic [PTR_W-1:0] rbin_q, rbin_d, rgray_d, rgray_q, wgray_s, wbin_s;
  logic             rd_ok;

  assign wr_ok  = wen_i & ~full_o;
  assign wbin_d = wbin_q + PTR_W'(wr_ok);

  gray_enc #(.W(PTR_W)) u_wenc (.bin_i(wbin_d), .gray_o(wgray_d));

  always_ff @(posedge wclk_i or negedge wrst_ni) begin
    if (!wrst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  ptr_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_rsync (
    .clk_i (wclk_i),
    .rst_ni(wrst_ni),
    .d_i   (rgray_q),
    .q_o   (rgray_s)
  );

  gray_dec #(.W(PTR_W)) u_rdec (.gray_i(rgray_s), .bin_o(rbin_s));

  assign full_o = (wbin_q[ADDR_W] != rbin_s[ADDR_W]) &&
                  (wbin_q[ADDR_W-1:0] == rbin_s[ADDR_W-1:0]);

  assign rd_ok  = ren_i & ~empty_o;
  assign rbin_d = rbin_q + PTR_W'(rd_ok);

  gray_enc #(.W(PTR_W)) u_renc (.bin_i(rbin_d), .gray_o(rgray_d));

  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
    end
  end

  ptr_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_wsync (
    .clk_i (rclk_i),
    .rst_ni(rrst_ni),
    .d_i   (wgray_q),
    .q_o   (wgray_s)
  );

  gray_dec #(.W(PTR_W)) u_wdec (.gray_i(wgray_s), .bin_o(wbin_s));

  assign empty_o = (rbin_q == wbin_s);

  fifo_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .wclk_i (wclk_i),
    .we_i   (wr_ok),
    .waddr_i(wbin_q[ADDR_W-1:0]),
    .wdata_i(wdata_i),
    .raddr_i(rbin_q[ADDR_W-1:0]),
    .rdata_o(rdata_o)
  );

  // R2: crossing Gray registers move one bit at a time
  p_wgray_step_r2: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
  p_rgray_step_r2: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);
  // R5: blocked requests leave pointers alone
  p_no_overflow_r5: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    full_o |=> $stable(wgray_q));
  p_no_underflow_r5: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    empty_o |=> $stable(rgray_q));
  // R7: full only once the local pointer is a whole depth ahead of the received one
  p_full_depth_r7: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    full_o |-> (wbin_q - rbin_s) == PTR_W'(1 << ADDR_W));
endmodule

// File: tb/afifo_gray_test.sv
`timescale 1ns / 100ps
module afifo_gray_test;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic wclk = 1'b0, rclk = 1'b0;
  logic wrst_n = 1'b0, rrst_n = 1'b0;
  logic wen = 1'b0, ren = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic full, empty;

  always #5 wclk = ~wclk;
  always #7.3 rclk = ~rclk;

  afifo_gray #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .wclk_i(wclk), .wrst_ni(wrst_n), .wen_i(wen), .wdata_i(wdata), .full_o(full),
    .rclk_i(rclk), .rrst_ni(rrst_n), .ren_i(ren), .rdata_o(rdata), .empty_o(empty)
  );

  int checks = 0, errors = 0;
  logic [DW-1:0] q[$];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  task automatic writer(input int p, input int n);
    int sent = 0;
    int cyc = 0;
    bit want;
    while (sent < n) begin
      @(negedge wclk);
      cyc++;
      chk(full || q.size() < DEPTH, "R4 no false not-full", q.size(), DEPTH - 1);
      case (p)
        0: want = 1'b1;
        1: want = (cyc % 3) == 0;
        default: want = ((cyc * 7 + 3) % 5) < 3;
      endcase
      wen = want;
      wdata = DW'(sent * 5 + p * 37);
      if (want && !full) begin
        q.push_back(wdata);
        sent++;
      end
    end
    @(negedge wclk);
    wen = 1'b0;
  endtask

  task automatic reader(input int p, input int n);
    int got = 0;
    int cyc = 0;
    bit want;
    while (got < n) begin
      @(negedge rclk);
      cyc++;
      chk(empty || q.size() > 0, "R3 no false not-empty", q.size(), 1);
      if (!empty && q.size() > 0)
        chk(rdata == q[0], "R1 order under traffic", rdata, q[0]);
      case (p)
        0: want = (cyc % 3) == 0;
        1: want = 1'b1;
        default: want = ((cyc * 3 + 1) % 4) < 2;
      endcase
      ren = want;
      if (want && !empty) begin
        void'(q.pop_front());
        got++;
      end
    end
    @(negedge rclk);
    ren = 1'b0;
  endtask

  initial begin
    int acc;
    repeat (3) @(negedge wclk);
    wrst_n = 1'b1;
    rrst_n = 1'b1;
    @(negedge rclk);
    @(negedge wclk);
    chk(empty == 1'b1, "R6 empty after reset", empty, 1);
    chk(full == 1'b0, "R6 full after reset", full, 0);

    // fill past depth; reads idle so full is exact
    acc = 0;
    for (int k = 0; k < DEPTH + 4; k++) begin
      @(negedge wclk);
      chk(full == (acc == DEPTH), "R7 full at depth", full, int'(acc == DEPTH));
      wen = 1'b1;
      wdata = DW'(k + 10);
      if (!full) begin
        q.push_back(wdata);
        acc++;
      end
    end
    @(negedge wclk);
    wen = 1'b0;
    chk(acc == DEPTH, "R7 accepted count", acc, DEPTH);
    chk(full == 1'b1, "R4 full held", full, 1);

    repeat (4) @(negedge rclk);
    for (int k = 0; k < DEPTH + 4; k++) begin
      @(negedge rclk);
      chk(empty == (q.size() == 0), "R3 empty exact when idle", empty, int'(q.size() == 0));
      if (!empty && q.size() > 0) chk(rdata == q[0], "R1 drain order", rdata, q[0]);
      ren = 1'b1;
      if (!empty) void'(q.pop_front());
    end
    @(negedge rclk);
    ren = 1'b0;
    chk(empty == 1'b1, "R5 extra reads leave empty", empty, 1);

    repeat (4) @(negedge wclk);
    chk(full == 1'b0, "R4 full falls within lag", full, 0);

    // reads while empty must not move the read pointer
    repeat (5) begin
      @(negedge rclk);
      ren = 1'b1;
    end
    @(negedge rclk);
    ren = 1'b0;
    @(negedge wclk);
    wen = 1'b1;
    wdata = 8'hA5;
    @(negedge wclk);
    wen = 1'b0;
    repeat (4) @(negedge rclk);
    chk(empty == 1'b0, "R3 empty falls within lag", empty, 0);
    chk(rdata == 8'hA5, "R5 read ptr unchanged by blocked reads", rdata, 8'hA5);
    ren = 1'b1;
    @(negedge rclk);
    ren = 1'b0;
    chk(empty == 1'b1, "R3 empty after last pop", empty, 1);

    for (int p = 0; p < 3; p++) begin
      fork
        writer(p, 200);
        reader(p, 200);
      join
      repeat (4) @(negedge rclk);
      chk(empty == 1'b1 && q.size() == 0, "R1 all words delivered", q.size(), 0);
    end
    finish_run();
  end
endmodule